// File: doc/BRIEF.md
# PLL register programming sequencer

This block is a hardware sequencer that loads a PLL controller's register bank from a set of divider settings and then confirms that the PLL has locked. On a start pulse it latches the input divider N, the feedback multiplier M, the comparator (reference-after-divide) frequency in hertz and four optional post-divider values. It then runs a fixed series of register transactions through a simple single-outstanding bus master. There is no other path to the register bank.

The bring-up has two phases. In the first phase the post-dividers stay bypassed and their clocks stay gated while the PLL locks. In the second phase only the post-dividers with a non-zero setting are enabled, and the sequencer waits for the acknowledge bit of each one. The GO and lock waits first poll back to back. After that they poll once per millisecond, and the length of a millisecond is a parameter given in clock cycles. The block reports success with a one-cycle `done` pulse. It reports an abort with a one-cycle `fail` pulse together with an error code that stays valid until the next accepted start.

Top module: `pll_prog_seq`

## Requirements
- R1: The first transaction writes configuration word 1 at address 0x0C. Its layout is: bit 0 = 1, bits 8:1 = N−1, bits 20:9 = M, bits 25:21 = post-divider 1 code, bits 30:26 = post-divider 2 code. A divider's code is value−1 when the value is non-zero and 0 when it is zero.
- R2: The second transaction writes configuration word 3 at address 0x14. Bits 4:0 hold the post-divider 3 code and bits 9:5 hold the post-divider 4 code, encoded as in R1.
- R3: Next, configuration word 2 (address 0x10) is read and then written back with these changes: bit 13 = 1, bit 14 = 0, bit 20 = 1, bits 22:21 = 3, and bits 16, 18, 23 and 25 = 0. All other bits keep the value that was read, apart from the field in R4.
- R4: In the write of R3, bits 4:1 carry a frequency code chosen from the comparator frequency F: 3 if F < 1 000 000, else 4 if F < 1 250 000, else 5 if F < 1 500 000, else 6 if F < 1 750 000, else 7.
- R5: The sequencer then writes 1 to address 0x08 (GO). It reads 0x08 until bit 0 is 0, and after that reads 0x04 (status) until bit 1 is 1.
- R6: Each of the two waits in R5 makes FAST_POLLS reads back to back. Before each further read it leaves the bus idle for exactly CYC_PER_MS cycles. After FAST_POLLS+SLOW_MS reads that all fail, it aborts with error code 1 (GO wait) or 2 (lock wait).
- R7: After lock, configuration word 2 is read again and written back with these changes: bit 14 = 1, bit 20 = 0, and bits 16, 18, 23 and 25 each set to 1 only when post-divider 1, 2, 3 or 4 respectively is non-zero. All other bits keep the value that was read.
- R8: The sequencer then reads status until every acknowledge bit of an enabled divider is 1. These are bits 7, 8, 10 and 11 for dividers 1 to 4. With no divider enabled, the first read succeeds. If ACK_POLLS reads all fail, it aborts with error code 3.
- R9: `done` (success) or `fail` (abort) is a one-cycle pulse in the cycle after the last transaction completes. On `done`, `err_code` is 0. The error code holds its value until the next accepted start, which clears it to 0. After reset, `done`, `fail`, `busy` and `bus_req` are 0 and `err_code` is 0.
- R10: A start pulse while `busy` is high is ignored. The running sequence and its latched settings are unchanged.
- R11: A transaction completes only in a cycle where `bus_req` and `bus_rdy` are both high. Read data is taken in that cycle. While waiting for ready, address, direction and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| n_div | input | NW | Input divider N (at least 1) |
| m_mult | input | MW | Feedback multiplier M |
| fint_hz | input | FW | Comparator frequency in hertz |
| post_div | input | 4*DIVW | Four post-divider values, divider i at bits [i*DIVW +: DIVW], 0 = unused |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle abort pulse |
| err_code | output | 2 | 0 none, 1 GO timeout, 2 lock timeout, 3 acknowledge timeout |
| bus_req | output | 1 | Transaction request, held until ready |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdy | input | 1 | Transaction completes in this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_rdy |

## Verification
The hardest cases to reach are the boundaries of the polling windows. These are a GO or lock wait that succeeds only after the back-to-back phase is over, a wait that uses every slow poll and aborts, and an acknowledge wait that succeeds on its very last allowed read. The bench reaches them with a behavioural register slave whose GO, lock and acknowledge responses are held off for a chosen number of reads. It uses a short millisecond so that the paced phase stays cheap. The bench counts idle bus cycles during each sequence and compares the total with the pacing that the hold-off count implies.

// File: rtl/pllseq_pkg.sv
// Shared definitions for the PLL programming sequencer.
// Assumes byte addresses on an 8-bit register bus with 32-bit data.
package pllseq_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] A_STATUS = 8'h04;
    localparam logic [BUS_AW-1:0] A_GO     = 8'h08;
    localparam logic [BUS_AW-1:0] A_CFG1   = 8'h0C;
    localparam logic [BUS_AW-1:0] A_CFG2   = 8'h10;
    localparam logic [BUS_AW-1:0] A_CFG3   = 8'h14;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_GO   = 2'd1,
        ERR_LOCK = 2'd2,
        ERR_ACK  = 2'd3
    } seq_err_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WCFG1, ST_WCFG3, ST_RCFG2A, ST_WCFG2A, ST_WGO,
        ST_PGO, ST_PLOCK, ST_RCFG2B, ST_WCFG2B, ST_PACK, ST_WAIT
    } seq_state_e;

    // Clock-enable bit in config word 2 for post-divider i
    function automatic int unsigned en_pos(input int i);
        case (i)
            0:       return 16;
            1:       return 18;
            2:       return 23;
            default: return 25;
        endcase
    endfunction

    // Acknowledge bit in the status word for post-divider i
    function automatic int unsigned ack_pos(input int i);
        case (i)
            0:       return 7;
            1:       return 8;
            2:       return 10;
            default: return 11;
        endcase
    endfunction

endpackage

// File: rtl/pllseq_freqsel.sv
// Maps the comparator frequency to the 4-bit range code.
// Assumes the thresholds are given in ascending order.
module pllseq_freqsel #(
    parameter int FW   = 32,
    parameter int LIM0 = 1000000,
    parameter int LIM1 = 1250000,
    parameter int LIM2 = 1500000,
    parameter int LIM3 = 1750000
) (
    input  logic [FW-1:0] fint,
    output logic [3:0]    code
);
    // Pick the first band whose upper limit exceeds the frequency
    always_comb begin
        if (fint < FW'(LIM0))      code = 4'd3;
        else if (fint < FW'(LIM1)) code = 4'd4;
        else if (fint < FW'(LIM2)) code = 4'd5;
        else if (fint < FW'(LIM3)) code = 4'd6;
        else                       code = 4'd7;
    end
endmodule

// File: rtl/pllseq_pack.sv
// Builds config words 1 and 3 plus the divider enable and acknowledge masks.
// Assumes 1 + NW + MW + 2*DIVW <= 32 and 2*DIVW <= 32.
module pllseq_pack import pllseq_pkg::*; #(
    parameter int NW   = 8,
    parameter int MW   = 12,
    parameter int DIVW = 5
) (
    input  logic [NW-1:0]     n_div,
    input  logic [MW-1:0]     m_mult,
    input  logic [4*DIVW-1:0] post_div,
    output logic [31:0]       cfg1,
    output logic [31:0]       cfg3,
    output logic [3:0]        en_mask,
    output logic [31:0]       ack_mask
);
    localparam int M_LO  = NW + 1;
    localparam int D0_LO = M_LO + MW;
    localparam int D1_LO = D0_LO + DIVW;

    logic [DIVW-1:0] code [4];

    // Per-divider code: value minus one, or zero when unused
    for (genvar i = 0; i < 4; i++) begin : g_code
        logic [DIVW-1:0] v;
        assign v          = post_div[i*DIVW +: DIVW];
        assign en_mask[i] = (v != '0);
        assign code[i]    = (v != '0) ? v - DIVW'(1) : '0;
    end

    // Assemble the two configuration words
    always_comb begin
        cfg1                 = '0;
        cfg1[0]              = 1'b1;
        cfg1[NW:1]           = n_div - NW'(1);
        cfg1[M_LO +: MW]     = m_mult;
        cfg1[D0_LO +: DIVW]  = code[0];
        cfg1[D1_LO +: DIVW]  = code[1];
        cfg3                 = '0;
        cfg3[0 +: DIVW]      = code[2];
        cfg3[DIVW +: DIVW]   = code[3];
    end

    // Status bits that must all be set once the enabled dividers are running
    always_comb begin
        ack_mask = '0;
        for (int i = 0; i < 4; i++) ack_mask[ack_pos(i)] = en_mask[i];
    end
endmodule

// File: rtl/pllseq_timer.sv
// Poll-interval timer: after a load it expires in the CYC-th cycle.
// Assumes CYC >= 1; idles at zero when not loaded.
module pllseq_timer #(
    parameter int CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int TW = $clog2(CYC + 1);

    logic [TW-1:0] cnt;

    // Down-counter reloaded on each wait request
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= TW'(CYC);
        else if (cnt != '0)  cnt <= cnt - TW'(1);
    end

    assign expired = (cnt == TW'(1));
endmodule

// File: rtl/pll_prog_seq.sv
// PLL register programming sequencer (top).
// Writes config 1 and 3, does read-modify-write of config 2 with the
// dividers bypassed, issues GO, waits for GO to clear and for lock, then
// enables the used dividers and waits for their acknowledges.
// Assumes a single-outstanding register bus: a transaction completes in the
// cycle where bus_req and bus_rdy are both high.
module pll_prog_seq import pllseq_pkg::*; #(
    parameter int NW         = 8,
    parameter int MW         = 12,
    parameter int DIVW       = 5,
    parameter int FW         = 32,
    parameter int FAST_POLLS = 100,
    parameter int SLOW_MS    = 500,
    parameter int CYC_PER_MS = 100000,
    parameter int ACK_POLLS  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NW-1:0]     n_div,
    input  logic [MW-1:0]     m_mult,
    input  logic [FW-1:0]     fint_hz,
    input  logic [4*DIVW-1:0] post_div,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [1:0]        err_code,
    output logic              bus_req,
    output logic              bus_we,
    output logic [7:0]        bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_rdy,
    input  logic [31:0]       bus_rdata
);
    localparam int PCW = $clog2(FAST_POLLS + SLOW_MS + ACK_POLLS + 1);
    localparam logic [PCW-1:0] WAIT_LAST = PCW'(FAST_POLLS + SLOW_MS - 1);
    localparam logic [PCW-1:0] FAST_M1   = PCW'(FAST_POLLS - 1);
    localparam logic [PCW-1:0] ACK_LAST  = PCW'(ACK_POLLS - 1);

    seq_state_e        state, ret_q;
    seq_err_e          err_q;
    logic [NW-1:0]     n_q;
    logic [MW-1:0]     m_q;
    logic [FW-1:0]     fint_q;
    logic [4*DIVW-1:0] div_q;
    logic [31:0]       c2_q, c2a, c2b, cfg1, cfg3, ack_mask;
    logic [3:0]        en_mask, fsel;
    logic [PCW-1:0]    pcnt;
    logic              xfer, poll_hit, timer_load, timer_exp;

    pllseq_pack #(.NW(NW), .MW(MW), .DIVW(DIVW)) u_pack (
        .n_div(n_q), .m_mult(m_q), .post_div(div_q),
        .cfg1(cfg1), .cfg3(cfg3), .en_mask(en_mask), .ack_mask(ack_mask)
    );

    pllseq_freqsel #(.FW(FW)) u_fsel (.fint(fint_q), .code(fsel));

    pllseq_timer #(.CYC(CYC_PER_MS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .expired(timer_exp)
    );

    // Config 2 images for the bypassed phase and the enabled phase
    always_comb begin
        c2a        = c2_q;
        c2a[4:1]   = fsel;
        c2a[13]    = 1'b1;
        c2a[14]    = 1'b0;
        c2a[20]    = 1'b1;
        c2a[22:21] = 2'b11;
        c2b        = c2_q;
        c2b[14]    = 1'b1;
        c2b[20]    = 1'b0;
        for (int i = 0; i < 4; i++) begin
            c2a[en_pos(i)] = 1'b0;
            c2b[en_pos(i)] = en_mask[i];
        end
    end

    // Bus request decode from the current step
    always_comb begin
        bus_req   = 1'b1;
        bus_we    = 1'b0;
        bus_addr  = A_STATUS;
        bus_wdata = '0;
        case (state)
            ST_WCFG1:             begin bus_we = 1'b1; bus_addr = A_CFG1; bus_wdata = cfg1; end
            ST_WCFG3:             begin bus_we = 1'b1; bus_addr = A_CFG3; bus_wdata = cfg3; end
            ST_RCFG2A, ST_RCFG2B: bus_addr = A_CFG2;
            ST_WCFG2A:            begin bus_we = 1'b1; bus_addr = A_CFG2; bus_wdata = c2a; end
            ST_WCFG2B:            begin bus_we = 1'b1; bus_addr = A_CFG2; bus_wdata = c2b; end
            ST_WGO:               begin bus_we = 1'b1; bus_addr = A_GO; bus_wdata = 32'd1; end
            ST_PGO:               bus_addr = A_GO;
            ST_PLOCK, ST_PACK:    bus_addr = A_STATUS;
            default:              bus_req = 1'b0;
        endcase
    end

    assign xfer = bus_req && bus_rdy;

    // Poll success condition for the step being polled
    always_comb begin
        case (state)
            ST_PGO:   poll_hit = !bus_rdata[0];
            ST_PLOCK: poll_hit = bus_rdata[1];
            ST_PACK:  poll_hit = ((bus_rdata & ack_mask) == ack_mask);
            default:  poll_hit = 1'b0;
        endcase
    end

    // A failed paced poll past the fast phase starts a one-interval wait
    assign timer_load = xfer && (state == ST_PGO || state == ST_PLOCK) && !poll_hit
                        && (pcnt != WAIT_LAST) && (pcnt >= FAST_M1);

    // Sequencer state, latched settings and result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ret_q  <= ST_IDLE;
            err_q  <= ERR_NONE;
            n_q    <= '0;
            m_q    <= '0;
            fint_q <= '0;
            div_q  <= '0;
            c2_q   <= '0;
            pcnt   <= '0;
            done   <= 1'b0;
            fail   <= 1'b0;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    n_q    <= n_div;
                    m_q    <= m_mult;
                    fint_q <= fint_hz;
                    div_q  <= post_div;
                    err_q  <= ERR_NONE;
                    state  <= ST_WCFG1;
                end
                ST_WAIT: if (timer_exp) state <= ret_q;
                default: if (xfer) begin
                    case (state)
                        ST_WCFG1:  state <= ST_WCFG3;
                        ST_WCFG3:  state <= ST_RCFG2A;
                        ST_RCFG2A: begin c2_q <= bus_rdata; state <= ST_WCFG2A; end
                        ST_WCFG2A: state <= ST_WGO;
                        ST_WGO:    begin pcnt <= '0; state <= ST_PGO; end
                        ST_PGO, ST_PLOCK: begin
                            if (poll_hit) begin
                                pcnt  <= '0;
                                state <= (state == ST_PGO) ? ST_PLOCK : ST_RCFG2B;
                            end else if (pcnt == WAIT_LAST) begin
                                fail  <= 1'b1;
                                err_q <= (state == ST_PGO) ? ERR_GO : ERR_LOCK;
                                state <= ST_IDLE;
                            end else begin
                                pcnt <= pcnt + PCW'(1);
                                if (timer_load) begin
                                    ret_q <= state;
                                    state <= ST_WAIT;
                                end
                            end
                        end
                        ST_RCFG2B: begin c2_q <= bus_rdata; state <= ST_WCFG2B; end
                        ST_WCFG2B: begin pcnt <= '0; state <= ST_PACK; end
                        ST_PACK: begin
                            if (poll_hit) begin
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end else if (pcnt == ACK_LAST) begin
                                fail  <= 1'b1;
                                err_q <= ERR_ACK;
                                state <= ST_IDLE;
                            end else begin
                                pcnt <= pcnt + PCW'(1);
                            end
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign err_code = err_q;
endmodule

// File: rtl/pllseq_chk.sv
// Protocol and result checker for the PLL programming sequencer.
// Assumes it is bound to pll_prog_seq and sees its ports only.
module pllseq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        fail,
    input logic [1:0]  err_code,
    input logic        bus_req,
    input logic        bus_we,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_rdy
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_rdy |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fail_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);

    assert_done_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !fail && err_code == 2'd0);

    assert_code_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(err_code));

    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && err_code == 2'd0);

    assert_fail_coded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> err_code != 2'd0 && !busy);
endmodule

bind pll_prog_seq pllseq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .err_code(err_code), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdy(bus_rdy)
);

// File: tb/sim_pll_prog_seq.sv
// Bench for pll_prog_seq: behavioural register slave plus a per-cycle
// reference model of the expected transaction stream and result pulses.
module sim_pll_prog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 8, MW = 12, DIVW = 5, FW = 32;
    localparam int FAST = 100, SLOW = 4, CYC = 3, ACKP = 100;
    localparam int TOT = FAST + SLOW;
    localparam int LIMIT = 150000;
    localparam logic [31:0] ALL_ACK = 32'h0000_0D80;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NW-1:0]     n_div = '0;
    logic [MW-1:0]     m_mult = '0;
    logic [FW-1:0]     fint_hz = '0;
    logic [4*DIVW-1:0] post_div = '0;
    logic              busy, done, fail, bus_req, bus_we;
    logic [1:0]        err_code;
    logic [7:0]        bus_addr;
    logic [31:0]       bus_wdata;
    logic              bus_rdy;
    logic [31:0]       bus_rdata;

    pll_prog_seq #(.NW(NW), .MW(MW), .DIVW(DIVW), .FW(FW), .FAST_POLLS(FAST),
                   .SLOW_MS(SLOW), .CYC_PER_MS(CYC), .ACK_POLLS(ACKP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .n_div(n_div), .m_mult(m_mult),
        .fint_hz(fint_hz), .post_div(post_div), .busy(busy), .done(done),
        .fail(fail), .err_code(err_code), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdy(bus_rdy),
        .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural register slave ----------------
    logic        cfg_load = 1'b0;
    logic [31:0] cfg2_init = '0;
    logic [31:0] ack_avail = '0;
    int          go_hold = 0, lock_hold = 0, ack_hold = 0;
    logic [31:0] s_cfg2 = '0;
    int          go_rd = 0, lock_rd = 0, ack_rd = 0, c2_wr = 0, wcnt = 0, txn_no = 0;
    logic        s_rdy = 1'b0;
    logic [31:0] s_rdata = '0;

    assign bus_rdy   = s_rdy;
    assign bus_rdata = s_rdata;

    always @(posedge clk) begin
        if (!rst_n || cfg_load) begin
            s_rdy <= 1'b0; wcnt <= 0;
            s_cfg2 <= cfg2_init; go_rd <= 0; lock_rd <= 0; ack_rd <= 0; c2_wr <= 0;
        end else if (s_rdy) begin
            s_rdy <= 1'b0;
        end else if (bus_req) begin
            if (wcnt >= txn_no % 3) begin
                s_rdy <= 1'b1; wcnt <= 0; txn_no <= txn_no + 1;
                s_rdata <= '0;
                if (bus_we) begin
                    if (bus_addr == 8'h10) begin s_cfg2 <= bus_wdata; c2_wr <= c2_wr + 1; end
                end else if (bus_addr == 8'h10) begin
                    s_rdata <= s_cfg2;
                end else if (bus_addr == 8'h08) begin
                    s_rdata <= (go_rd < go_hold) ? 32'd1 : 32'd0; go_rd <= go_rd + 1;
                end else if (bus_addr == 8'h04) begin
                    if (c2_wr >= 2) begin
                        s_rdata <= 32'h3 | ((ack_rd >= ack_hold) ? ack_avail : 32'h0); ack_rd <= ack_rd + 1;
                    end else begin
                        s_rdata <= 32'h1 | ((lock_rd >= lock_hold) ? 32'h2 : 32'h0); lock_rd <= lock_rd + 1;
                    end
                end
            end else wcnt <= wcnt + 1;
        end
    end

    // ---------------- reference model and checks ----------------
    int          checks = 0, fails = 0, cyc = 0;
    logic        exp_we   [512];
    logic [7:0]  exp_addr [512];
    logic [31:0] exp_data [512];
    string       exp_tag  [512];
    int          exp_len = 0, rd_idx = 0, gap = 0, exp_gap = 0;
    bit          active = 0, fin_pending = 0, exp_fail = 0;
    logic [1:0]  exp_code = '0;
    logic [3:0]  exp_fsel = '0;
    string       fin_tag = "R9";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // One clock: sample away from the edge and compare with the model
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (cyc > LIMIT) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
            report();
            $finish;
        end
        if (rst_n) begin
            if (fin_pending) begin
                chk(done == !exp_fail, "R9", "done pulse", 32'(done), 32'(!exp_fail));
                chk(fail == exp_fail, fin_tag, "fail pulse", 32'(fail), 32'(exp_fail));
                chk(err_code == exp_code, fin_tag, "error code", 32'(err_code), 32'(exp_code));
                chk(gap == exp_gap, "R6", "idle poll cycles", 32'(gap), 32'(exp_gap));
                fin_pending = 0;
                active = 0;
            end else begin
                chk(!done && !fail, "R9", "stray result pulse", {30'd0, done, fail}, 32'd0);
            end
            if (active && busy && !bus_req) gap++;
            if (bus_req && bus_rdy) begin
                if (!active || rd_idx >= exp_len) begin
                    chk(0, "R10", "unexpected transaction", 32'(bus_addr), 32'hFFFF_FFFF);
                end else begin
                    chk(bus_we == exp_we[rd_idx] && bus_addr == exp_addr[rd_idx], exp_tag[rd_idx],
                        "address/direction", {23'd0, bus_we, bus_addr}, {23'd0, exp_we[rd_idx], exp_addr[rd_idx]});
                    if (exp_we[rd_idx])
                        chk(bus_wdata == exp_data[rd_idx], exp_tag[rd_idx], "write data", bus_wdata, exp_data[rd_idx]);
                    if (exp_we[rd_idx] && exp_tag[rd_idx] == "R3")
                        chk(bus_wdata[4:1] == exp_fsel, "R4", "frequency code", 32'(bus_wdata[4:1]), 32'(exp_fsel));
                    rd_idx++;
                    if (rd_idx == exp_len) fin_pending = 1;
                end
            end
        end
    endtask

    task automatic push(input logic we, input logic [7:0] a, input logic [31:0] d, input string tag);
        exp_we[exp_len] = we; exp_addr[exp_len] = a; exp_data[exp_len] = d; exp_tag[exp_len] = tag;
        exp_len++;
    endtask

    function automatic logic [DIVW-1:0] enc(input int v);
        return (v != 0) ? DIVW'(v - 1) : '0;
    endfunction

    // Build the expected stream, run one sequence and wait for its result
    task automatic run_seq(input int n, input int m, input int f, input int d0, input int d1,
                           input int d2, input int d3, input logic [31:0] c2i, input int gh,
                           input int lh, input int ah, input logic [31:0] avail, input bit mid);
        logic [31:0] c1, c3, c2a, c2b, need;
        int waits, polls, f0;
        cfg2_init = c2i; go_hold = gh; lock_hold = lh; ack_hold = ah; ack_avail = avail;
        cfg_load = 1; tick(); cfg_load = 0;
        exp_len = 0; rd_idx = 0; gap = 0; waits = 0; exp_fail = 0; exp_code = 2'd0; fin_tag = "R9";
        exp_fsel = (f < 1000000) ? 4'd3 : (f < 1250000) ? 4'd4 : (f < 1500000) ? 4'd5 :
                   (f < 1750000) ? 4'd6 : 4'd7;
        c1 = 32'd1 | (32'((n - 1) & 8'hFF) << 1) | (32'(m) << 9) | (32'(enc(d0)) << 21) | (32'(enc(d1)) << 26);
        c3 = 32'(enc(d2)) | (32'(enc(d3)) << 5);
        c2a = c2i; c2a[4:1] = exp_fsel; c2a[13] = 1; c2a[14] = 0; c2a[16] = 0; c2a[18] = 0;
        c2a[20] = 1; c2a[22:21] = 2'b11; c2a[23] = 0; c2a[25] = 0;
        c2b = c2a; c2b[14] = 1; c2b[20] = 0; c2b[16] = (d0 != 0); c2b[18] = (d1 != 0);
        c2b[23] = (d2 != 0); c2b[25] = (d3 != 0);
        need = {20'd0, d3 != 0, d2 != 0, 1'b0, d1 != 0, d0 != 0, 7'd0};
        push(1, 8'h0C, c1, "R1"); push(1, 8'h14, c3, "R2");
        push(0, 8'h10, 0, "R3"); push(1, 8'h10, c2a, "R3"); push(1, 8'h08, 32'd1, "R5");
        polls = (gh >= TOT) ? TOT : gh + 1;
        for (int i = 0; i < polls; i++) push(0, 8'h08, 0, "R5");
        waits += (polls > FAST) ? polls - FAST : 0;
        if (gh >= TOT) begin exp_fail = 1; exp_code = 2'd1; fin_tag = "R6"; waits = SLOW; end
        else begin
            polls = (lh >= TOT) ? TOT : lh + 1;
            for (int i = 0; i < polls; i++) push(0, 8'h04, 0, "R6");
            waits += (lh >= TOT) ? SLOW : ((polls > FAST) ? polls - FAST : 0);
            if (lh >= TOT) begin exp_fail = 1; exp_code = 2'd2; fin_tag = "R6"; end
            else begin
                push(0, 8'h10, 0, "R7"); push(1, 8'h10, c2b, "R7");
                if ((avail & need) != need) begin
                    for (int i = 0; i < ACKP; i++) push(0, 8'h04, 0, "R8");
                    exp_fail = 1; exp_code = 2'd3; fin_tag = "R8";
                end else begin
                    polls = (need == 0) ? 1 : ah + 1;
                    for (int i = 0; i < polls; i++) push(0, 8'h04, 0, "R8");
                end
            end
        end
        exp_gap = waits * CYC;
        n_div = NW'(n); m_mult = MW'(m); fint_hz = FW'(f);
        post_div = {DIVW'(d3), DIVW'(d2), DIVW'(d1), DIVW'(d0)};
        active = 1; start = 1; tick(); start = 0;
        chk(busy && err_code == 2'd0, "R9", "accepted start clears code", {30'd0, busy, |err_code}, 32'd2);
        f0 = fails;
        for (int k = 0; active; k++) begin
            if (mid && k == 12) begin
                n_div = NW'(n + 7); post_div = '1; start = 1; tick(); start = 0;
            end else tick();
        end
        if (mid) chk(fails == f0, "R10", "start while busy changed the sequence", 32'(fails), 32'(f0));
        for (int i = 0; i < 3; i++) tick();
    endtask

    initial begin
        for (int i = 0; i < 3; i++) tick();
        chk(!busy && !done && !fail && !bus_req && err_code == 0, "R9", "reset state",
            {27'd0, busy, done, fail, bus_req, |err_code}, 32'd0);
        rst_n = 1; tick();
        chk(!busy && !bus_req && err_code == 0, "R9", "after reset", {29'd0, busy, bus_req, |err_code}, 32'd0);
        // main function, several divider patterns and all frequency bands (R1-R4 tags in model)
        run_seq(5, 300, 999999, 3, 0, 7, 1, 32'h5A5A_A5A5, 2, 3, 2, ALL_ACK, 1);
        run_seq(1, 4095, 1000000, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 32'h0, 0);
        run_seq(200, 1, 1249999, 31, 1, 0, 2, 32'h0, 1, 0, 5, ALL_ACK, 0);
        run_seq(255, 77, 1250000, 1, 1, 1, 1, 32'hA5A5_5A5A, 0, 1, 1, ALL_ACK, 0);
        run_seq(9, 512, 1749999, 0, 4, 0, 0, 32'h1234_5678, 0, 0, 0, ALL_ACK, 0);
        run_seq(3, 1000, 1750000, 2, 31, 5, 0, 32'hFEDC_BA98, 0, 0, 0, ALL_ACK, 0);
        // R6: GO clears only in the paced phase
        run_seq(4, 100, 1500000, 1, 2, 3, 4, 32'h0, 103, 0, 0, ALL_ACK, 0);
        // R6: GO never clears -> code 1, then code held while idle (R9)
        run_seq(4, 100, 1500000, 1, 2, 3, 4, 32'h0, 1000, 0, 0, ALL_ACK, 0);
        for (int i = 0; i < 10; i++) tick();
        chk(err_code == 2'd1, "R9", "code held while idle", 32'(err_code), 32'd1);
        // R6: lock late in the paced phase, then lock timeout -> code 2
        run_seq(6, 50, 800000, 0, 3, 0, 0, 32'h0F0F_0F0F, 0, 101, 0, ALL_ACK, 0);
        run_seq(6, 50, 800000, 0, 3, 0, 0, 32'h0F0F_0F0F, 0, 1000, 0, ALL_ACK, 0);
        // R8: acknowledge on the last allowed read, then a missing acknowledge -> code 3
        run_seq(2, 20, 2000000, 1, 2, 3, 4, 32'h0, 0, 0, 99, ALL_ACK, 0);
        run_seq(2, 20, 2000000, 1, 2, 3, 4, 32'h0, 0, 0, 0, ALL_ACK & ~32'h400, 0);
        report();
        $finish;
    end
endmodule